// File: doc/BRIEF.md
# Link Bring-Up Retry Sequencer

This block brings a serial link port out of reset and decides whether the link is usable. Each attempt has two timed phases. Phase one waits for the data-link-layer-up status. Phase two waits for the link-trained status. Both phases measure time in millisecond ticks supplied from outside the block. If either phase runs out of time, the sequencer asserts the port reset for a fixed number of ticks, releases it, and starts a new attempt. It stops after a bounded number of attempts.

Software or a power-up controller pulses `start_i` once. It then waits for the single-cycle `done_o` strobe and reads `link_up_o`, which holds its value until the next accepted start. The block does not generate the tick and does not model the physical layer. It only samples the two status bits.

Top module: `lnk_bringup_seq`

## Requirements
- R1: After reset, `port_rst_o`, `done_o` and `link_up_o` are all 0 and the sequencer is idle.
- R2: Phase one watches only `dl_up_i`; `lnk_ok_i` has no effect there. If `DL_WAIT_TICKS` ticks pass without `dl_up_i`, `port_rst_o` rises in the cycle after the last of those ticks, and phase two is skipped.
- R3: Once `dl_up_i` is sampled high, phase two begins. A high `lnk_ok_i` sampled in phase two raises `done_o` and sets `link_up_o` to 1 in the next cycle.
- R4: If `LS_WAIT_TICKS` ticks pass in phase two without `lnk_ok_i`, `port_rst_o` rises in the cycle after the last of those ticks.
- R5: Every reset pulse keeps `port_rst_o` high for exactly `RST_TICKS` ticks, then drops it. A new attempt starts in that same cycle, or the run finishes.
- R6: At most `MAX_ATTEMPTS` attempts are made, and one reset pulse follows each failed attempt. When the pulse after the final failure ends, `done_o` rises with `link_up_o` = 0.
- R7: Both phase timers reload to their full limits at the start of every attempt, so each attempt gets the whole timeout.
- R8: `done_o` is high for exactly one cycle and is never high together with `port_rst_o`. `link_up_o` changes only together with `done_o`, or in the cycle after an accepted start, which clears it to 0.
- R9: A `start_i` pulse that arrives while a run is in progress is ignored. It does not disturb the timers, the attempt count or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin bring-up |
| dl_up_i | input | 1 | Data-link-layer-up status from the port |
| lnk_ok_i | input | 1 | Link-trained status from the port |
| ms_tick_i | input | 1 | One-cycle pulse marking each millisecond |
| port_rst_o | output | 1 | Reset to the port, high while a retry pulse runs |
| done_o | output | 1 | One-cycle strobe when the run finishes |
| link_up_o | output | 1 | Result of the last run, 1 when the link came up |

## Verification
The bench uses a small configuration with 5-tick timeouts, 2-tick pulses and three attempts. It sweeps every attempt index at which the link can succeed (first, second, third, never), combined with both failure kinds: a missing data-link status, and a data-link status with no link-trained status. The tick count at which each reset rises tells the two failure kinds apart, and it also shows whether the timers were reloaded. The number of reset pulses and the final result show the attempt bound. One extra run raises the link-trained bit before the data-link bit, which checks that phase one ignores it. Another run sends a second start in the middle of a run, which checks that the tick count is unaffected.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DL_WAIT = 2'd1,
    ST_LS_WAIT = 2'd2,
    ST_PULSE   = 2'd3
  } lbs_state_e;

  // Bits needed to hold values 0..limit.
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // A countdown expires on the tick that consumes its last unit.
  function automatic logic expires_now(input logic run, input logic tick,
                                       input int unsigned remain);
    return run && tick && (remain == 1);
  endfunction

endpackage

// File: rtl/lbs_tick_timer.sv
module lbs_tick_timer #(
  parameter int unsigned LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned W = lbs_pkg::cnt_width(LIMIT);

  logic [W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= W'(LIMIT);
    end else if (run_i && tick_i && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expire_o = lbs_pkg::expires_now(run_i, tick_i, int'(remain_q));

endmodule

// File: rtl/lbs_attempt_ctr.sv
module lbs_attempt_ctr #(
  parameter int unsigned ATTEMPTS = 3,
  parameter int unsigned AW       = lbs_pkg::cnt_width(ATTEMPTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          incr_i,
  output logic [AW-1:0] count_o,
  output logic          last_o
);
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (incr_i && !last_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == AW'(ATTEMPTS - 1));

endmodule

// File: rtl/lbs_seq_fsm.sv
module lbs_seq_fsm
  import lbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       dl_up_i,
  input  logic       lnk_ok_i,
  input  logic       to_dl_i,
  input  logic       to_ls_i,
  input  logic       rst_end_i,
  input  logic       last_i,
  output lbs_state_e state_o,
  output logic       load_dl_o,
  output logic       load_ls_o,
  output logic       load_rst_o,
  output logic       att_clr_o,
  output logic       att_inc_o,
  output logic       ev_to_dl_o,
  output logic       ev_to_ls_o,
  output logic       done_o,
  output logic       link_up_o
);
  lbs_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       up_q, up_d;

  always_comb begin
    state_d    = state_q;
    load_dl_o  = 1'b0;
    load_ls_o  = 1'b0;
    load_rst_o = 1'b0;
    att_clr_o  = 1'b0;
    att_inc_o  = 1'b0;
    ev_to_dl_o = 1'b0;
    ev_to_ls_o = 1'b0;
    done_d     = 1'b0;
    up_d       = up_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_DL_WAIT;
          load_dl_o = 1'b1;
          att_clr_o = 1'b1;
          up_d      = 1'b0;
        end
      end
      ST_DL_WAIT: begin
        if (dl_up_i) begin
          state_d   = ST_LS_WAIT;
          load_ls_o = 1'b1;
        end else if (to_dl_i) begin
          state_d    = ST_PULSE;
          load_rst_o = 1'b1;
          ev_to_dl_o = 1'b1;
        end
      end
      ST_LS_WAIT: begin
        if (lnk_ok_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          up_d    = 1'b1;
        end else if (to_ls_i) begin
          state_d    = ST_PULSE;
          load_rst_o = 1'b1;
          ev_to_ls_o = 1'b1;
        end
      end
      ST_PULSE: begin
        if (rst_end_i) begin
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            up_d    = 1'b0;
          end else begin
            state_d   = ST_DL_WAIT;
            load_dl_o = 1'b1;
            att_inc_o = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      up_q    <= up_d;
    end
  end

  assign state_o   = state_q;
  assign done_o    = done_q;
  assign link_up_o = up_q;

endmodule

// File: rtl/lnk_bringup_seq.sv
module lnk_bringup_seq
  import lbs_pkg::*;
#(
  parameter int unsigned DL_WAIT_TICKS = 200,
  parameter int unsigned LS_WAIT_TICKS = 200,
  parameter int unsigned RST_TICKS     = 1,
  parameter int unsigned MAX_ATTEMPTS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic dl_up_i,
  input  logic lnk_ok_i,
  input  logic ms_tick_i,
  output logic port_rst_o,
  output logic done_o,
  output logic link_up_o
);
  localparam int unsigned AW = cnt_width(MAX_ATTEMPTS);

  lbs_state_e    st_w;
  logic          load_dl_w, load_ls_w, load_rst_w;
  logic          att_clr_w, att_inc_w, att_last_w;
  logic          to_dl_w, to_ls_w, rst_end_w;
  logic          ev_to_dl_w, ev_to_ls_w;
  logic [AW-1:0] att_cnt_w;

  lbs_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dl_up_i    (dl_up_i),
    .lnk_ok_i   (lnk_ok_i),
    .to_dl_i    (to_dl_w),
    .to_ls_i    (to_ls_w),
    .rst_end_i  (rst_end_w),
    .last_i     (att_last_w),
    .state_o    (st_w),
    .load_dl_o  (load_dl_w),
    .load_ls_o  (load_ls_w),
    .load_rst_o (load_rst_w),
    .att_clr_o  (att_clr_w),
    .att_inc_o  (att_inc_w),
    .ev_to_dl_o (ev_to_dl_w),
    .ev_to_ls_o (ev_to_ls_w),
    .done_o     (done_o),
    .link_up_o  (link_up_o)
  );

  lbs_tick_timer #(.LIMIT(DL_WAIT_TICKS)) u_dl_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_dl_w),
    .run_i    (st_w == ST_DL_WAIT),
    .tick_i   (ms_tick_i),
    .expire_o (to_dl_w)
  );

  lbs_tick_timer #(.LIMIT(LS_WAIT_TICKS)) u_ls_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_ls_w),
    .run_i    (st_w == ST_LS_WAIT),
    .tick_i   (ms_tick_i),
    .expire_o (to_ls_w)
  );

  lbs_tick_timer #(.LIMIT(RST_TICKS)) u_rst_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_rst_w),
    .run_i    (st_w == ST_PULSE),
    .tick_i   (ms_tick_i),
    .expire_o (rst_end_w)
  );

  lbs_attempt_ctr #(.ATTEMPTS(MAX_ATTEMPTS), .AW(AW)) u_att (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (att_clr_w),
    .incr_i  (att_inc_w),
    .count_o (att_cnt_w),
    .last_o  (att_last_w)
  );

  assign port_rst_o = (st_w == ST_PULSE);

endmodule

// File: rtl/lbs_checker.sv
module lbs_checker
  import lbs_pkg::*;
#(
  parameter int unsigned MAX_ATTEMPTS = 3,
  parameter int unsigned AW           = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          lnk_ok_i,
  input logic          port_rst_o,
  input logic          done_o,
  input logic          link_up_o,
  input lbs_state_e    st,
  input logic          ev_to_dl,
  input logic          ev_to_ls,
  input logic [AW-1:0] att_cnt
);

  a_r2_skip_phase_two: assert property (@(posedge clk) disable iff (!rst_n)
    ev_to_dl |=> port_rst_o);

  a_r4_phase_two_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    ev_to_ls |=> port_rst_o);

  a_r3_success_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LS_WAIT && lnk_ok_i) |=> (done_o && link_up_o));

  a_r6_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    att_cnt < AW'(MAX_ATTEMPTS));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_done_not_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_o |-> !done_o);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(link_up_o) |-> (done_o || $past(start_i)));

  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && st != ST_IDLE && att_cnt != '0) |=> att_cnt != '0);

endmodule

bind lnk_bringup_seq lbs_checker #(
  .MAX_ATTEMPTS (MAX_ATTEMPTS),
  .AW           (AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .lnk_ok_i   (lnk_ok_i),
  .port_rst_o (port_rst_o),
  .done_o     (done_o),
  .link_up_o  (link_up_o),
  .st         (st_w),
  .ev_to_dl   (ev_to_dl_w),
  .ev_to_ls   (ev_to_ls_w),
  .att_cnt    (att_cnt_w)
);

// File: tb/lnk_bringup_seq_tb.sv
module lnk_bringup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO         = 5;
  localparam int RT         = 2;
  localparam int NA         = 3;
  localparam int TICK_DIV   = 4;
  localparam int DLY        = 2;
  localparam int CASE_LIMIT = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, dl_up_i = 1'b0, lnk_ok_i = 1'b0, ms_tick_i = 1'b0;
  logic port_rst_o, done_o, link_up_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lnk_bringup_seq #(
    .DL_WAIT_TICKS (TO),
    .LS_WAIT_TICKS (TO),
    .RST_TICKS     (RT),
    .MAX_ATTEMPTS  (NA)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dl_up_i    (dl_up_i),
    .lnk_ok_i   (lnk_ok_i),
    .ms_tick_i  (ms_tick_i),
    .port_rst_o (port_rst_o),
    .done_o     (done_o),
    .link_up_o  (link_up_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // succ: attempt index that succeeds (NA = never)
  // mode: 0 = failing attempts lack dl_up, 1 = dl_up but no lnk_ok
  task automatic run_case(input int succ, input int mode, input bit lnk_early,
                          input bit busy_start);
    int att = 0, att_ticks = 0, rst_ticks = 0, falls = 0, cyc = 0, tdiv = 0;
    bit prev_rst = 1'b0, fin = 1'b0;
    int exp_rise;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(link_up_o == 1'b0, "R8", "result cleared after start", link_up_o, 0);
    while (!fin && cyc < CASE_LIMIT) begin
      if (port_rst_o && !prev_rst) begin
        exp_rise = (mode == 1) ? DLY + TO : TO;
        // R2 (mode 0) / R4 (mode 1) / R7 reload each attempt
        chk(att_ticks == exp_rise, mode == 1 ? "R4" : "R2",
            "ticks before reset rise", att_ticks, exp_rise);
        chk(att_ticks == exp_rise, "R7", "timer reload per attempt",
            att_ticks, exp_rise);
        rst_ticks = 0;
      end
      if (!port_rst_o && prev_rst) begin
        chk(rst_ticks == RT, "R5", "reset pulse width", rst_ticks, RT);
        falls++;
        att++;
        att_ticks = 0;
      end
      prev_rst = port_rst_o;
      if (done_o) begin
        fin = 1'b1;
      end else begin
        ms_tick_i = (tdiv == TICK_DIV - 1);
        tdiv = (tdiv + 1) % TICK_DIV;
        dl_up_i = !port_rst_o && ((att == succ) || (mode == 1)) &&
                  (att_ticks >= DLY);
        if (att == succ)
          lnk_ok_i = !port_rst_o && (lnk_early || (att_ticks >= DLY + 1));
        else
          lnk_ok_i = 1'b0;
        start_i = busy_start && (cyc == 7);
        if (ms_tick_i) begin
          if (port_rst_o) rst_ticks++;
          else att_ticks++;
        end
        cyc++;
        @(negedge clk);
      end
    end
    ms_tick_i = 1'b0; dl_up_i = 1'b0; lnk_ok_i = 1'b0; start_i = 1'b0;
    chk(fin, "R6", "run finished before watchdog", fin, 1);
    if (fin) begin
      chk(falls == ((succ < NA) ? succ : NA), "R6", "reset pulse count",
          falls, (succ < NA) ? succ : NA);
      chk(link_up_o == (succ < NA), "R6", "final result", link_up_o,
          (succ < NA) ? 1 : 0);
      chk(!port_rst_o, "R8", "no reset with done", port_rst_o, 0);
      if (succ < NA)
        // R3 done in cycle after lnk_ok seen; R2 lnk_ok ignored in phase one
        chk(att_ticks == (lnk_early ? DLY : DLY + 1), lnk_early ? "R2" : "R3",
            "ticks to success", att_ticks, lnk_early ? DLY : DLY + 1);
      @(negedge clk);
      chk(done_o == 1'b0, "R8", "done lasts one cycle", done_o, 0);
      repeat (6) @(negedge clk);
      chk(link_up_o == (succ < NA), "R8", "result held", link_up_o,
          (succ < NA) ? 1 : 0);
      chk(!port_rst_o && !done_o, "R1", "idle after run", port_rst_o, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!port_rst_o && !done_o && !link_up_o, "R1", "reset outputs",
        {port_rst_o, done_o, link_up_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!port_rst_o && !done_o && !link_up_o, "R1", "idle after reset",
        {port_rst_o, done_o, link_up_o}, 0);
    for (int s = 0; s <= NA; s++)
      for (int m = 0; m < 2; m++)
        run_case(s, m, 1'b0, 1'b0);
    run_case(1, 0, 1'b1, 1'b0);   // R2: early lnk_ok ignored in phase one
    run_case(0, 0, 1'b0, 1'b1);   // R9: start during a run ignored
    run_case(NA, 1, 1'b0, 1'b1);  // R9 with all attempts failing
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule